// File: doc/BRIEF.md
# Masked Vector Element Unit

This block carries out one element-wise operation over two source vectors of up to `N` elements, each `W` bits wide. It holds a per-element mask register that decides which results are written back. Vector compare and test operations rewrite the mask, and a complement operation inverts it so that the opposite selection can follow. Arithmetic operations (add, multiply) produce one destination write per active element on a write port.

Arithmetic operations run in one of two execution modes, chosen per operation. In the sweep mode every element position below the vector length is visited in index order, one per cycle, and writeback is suppressed where the mask bit is clear. In the packed mode the unit first spends one cycle scanning the mask, then issues only the active elements, lowest index first, one per cycle. The packed mode saves cycles on sparse masks at the cost of the scan cycle. A one-cycle `done` pulse closes every operation. The caller keeps `src_a` and `src_b` stable until `done`.

Top module: `vmask_exec`

## Requirements
- R1: After reset the mask is all ones. Mask operations (op codes 2 to 5) update the mask in the clock edge that accepts them, make no writes, and raise `done` in the first cycle after that edge. Op codes 6 and 7 leave the mask unchanged, make no writes and also raise `done` in that cycle.
- R2: Op code 2 sets mask bit i to (a[i] >= b[i]), with both elements taken as unsigned values.
- R3: Op code 3 sets mask bit i to (a[i] == 0). Op code 4 sets mask bit i to (a[i] != 0).
- R4: Op code 5 inverts every mask bit whose index is below the effective vector length.
- R5: Op code 0 writes the low `W` bits of a[i]+b[i]. Op code 1 writes the low `W` bits of a[i]*b[i].
- R6: In sweep mode (`dense`=0) element i is visited in cycle i+1 after the accepting edge, for i from 0 to length-1. `wr_en` is high in that cycle exactly when mask bit i is 1.
- R7: In packed mode (`dense`=1) cycle 1 is a scan cycle with no write. The k-th active element (k from 0, ascending index) is written in cycle k+2.
- R8: The effective length is `vlen`, clamped to `N` when larger. No element at or above it is written. Mask operations (codes 2 to 5) clear the mask bits at or above it.
- R9: `done` is a single-cycle pulse. It comes in cycle length+1 for sweep mode (cycle 1 when the length is 0) and in cycle count+2 for packed mode (cycle 2 when no element is active).
- R10: `busy` is high from the cycle after acceptance through the `done` cycle. A `start` seen while `busy` is high is ignored and changes neither the running operation nor the mask. After reset `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation, accepted when not busy |
| op | input | 3 | Operation code: 0 add, 1 multiply, 2 compare ge, 3 test zero, 4 test nonzero, 5 complement mask |
| vlen | input | $clog2(N+1) | Vector length for this operation |
| dense | input | 1 | 1 selects packed (skip inactive) mode for arithmetic |
| src_a | input | N*W | Source vector A, element i at bits [i*W +: W] |
| src_b | input | N*W | Source vector B, element i at bits [i*W +: W] |
| busy | output | 1 | Operation in progress |
| wr_en | output | 1 | Destination element write strobe |
| wr_idx | output | $clog2(N) | Destination element index |
| wr_data | output | W | Destination element value |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every result has a fixed due cycle counted from the edge that accepts `start`. Mask updates land on that edge, with `done` one cycle later. In sweep mode element i falls in cycle i+1 and `done` in cycle length+1. In packed mode the scan takes cycle 1, active element k falls in cycle k+2, and `done` comes one cycle after the last write. The bench counts falling edges from acceptance, records the cycle number of each write and of `done`, and compares those numbers with the due cycles it works out from its own mask model. It checks mask contents through the writes of a later arithmetic operation.

// File: rtl/vmask_pkg.sv
package vmask_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_MUL = 3'd1,
    OP_CGE = 3'd2,
    OP_TZ  = 3'd3,
    OP_TNZ = 3'd4,
    OP_INV = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } vop_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RUN,
    ST_FIN
  } seq_st_e;

  function automatic logic is_alu_op(input logic [2:0] o);
    return (o == OP_ADD) || (o == OP_MUL);
  endfunction

  function automatic logic is_mask_write(input logic [2:0] o);
    return (o >= OP_CGE) && (o <= OP_INV);
  endfunction

endpackage

// File: rtl/vmask_reg.sv
module vmask_reg
  import vmask_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  localparam int LW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [2:0]     op,
  input  logic [LW-1:0]  vlen_eff,
  input  logic [N*W-1:0] src_a,
  input  logic [N*W-1:0] src_b,
  output logic [N-1:0]   mask
);

  logic [N-1:0] mask_nxt;

  function automatic logic lane_next(input logic [2:0] o, input logic on,
                                     input logic [W-1:0] x, input logic [W-1:0] y,
                                     input logic cur);
    case (vop_e'(o))
      OP_CGE:  return on & (x >= y);
      OP_TZ:   return on & (x == '0);
      OP_TNZ:  return on & (x != '0);
      OP_INV:  return on & ~cur;
      default: return cur;
    endcase
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_lane
    logic [W-1:0] a_e;
    logic [W-1:0] b_e;
    logic         on;
    assign a_e = src_a[g*W +: W];
    assign b_e = src_b[g*W +: W];
    assign on  = LW'(g) < vlen_eff;
    assign mask_nxt[g] = lane_next(op, on, a_e, b_e, mask[g]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  mask <= '1;
    else if (we) mask <= mask_nxt;
  end

  // R1: the mask only moves when a mask operation is accepted
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> mask == $past(mask));

  // R8: mask operations leave no bit set at or above the length
  p_mask_tail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && is_mask_write(op)) |=> ((mask >> $past(vlen_eff)) == '0));

endmodule

// File: rtl/vmask_seq.sv
module vmask_seq
  import vmask_pkg::*;
#(
  parameter int N = 8,
  localparam int LW = $clog2(N + 1),
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          alu,
  input  logic          dense_in,
  input  logic [LW-1:0] vlen_eff,
  input  logic [N-1:0]  mask,
  output logic          busy,
  output logic          run,
  output logic          pick,
  output logic [IW-1:0] idx,
  output logic          done
);

  seq_st_e       st;
  logic          dense_q;
  logic [LW-1:0] len_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  pend;
  logic [N-1:0]  live;
  logic [IW-1:0] first;

  function automatic logic [N-1:0] len_bits(input logic [LW-1:0] l);
    logic [N-1:0] m;
    for (int i = 0; i < N; i++) m[i] = LW'(i) < l;
    return m;
  endfunction

  function automatic logic [IW-1:0] low_bit(input logic [N-1:0] p);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = IW'(i);
    return r;
  endfunction

  assign live  = mask & len_bits(len_q);
  assign first = low_bit(pend);
  assign busy  = st != ST_IDLE;
  assign run   = st == ST_RUN;
  assign done  = st == ST_FIN;
  assign idx   = dense_q ? first : idx_q;
  assign pick  = run & (dense_q | mask[idx_q]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      dense_q <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      pend    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go) begin
          len_q   <= vlen_eff;
          dense_q <= dense_in;
          idx_q   <= '0;
          if (!alu)                st <= ST_FIN;
          else if (dense_in)       st <= ST_SCAN;
          else if (vlen_eff == '0) st <= ST_FIN;
          else                     st <= ST_RUN;
        end
        ST_SCAN: begin
          pend <= live;
          st   <= (live != '0) ? ST_RUN : ST_FIN;
        end
        ST_RUN: begin
          if (dense_q) begin
            pend <= pend & ~(N'(1) << first);
            if ($countones(pend) == 1) st <= ST_FIN;
          end else begin
            idx_q <= idx_q + IW'(1);
            if (LW'(idx_q) + LW'(1) == len_q) st <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: done lasts exactly one cycle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: an accepted request makes the unit busy
  p_busy_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> busy);

  // R8: no element at or above the length is issued
  p_in_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (LW'(idx) < len_q));

  // R7: packed issue moves to strictly higher indices
  p_dense_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dense_q && $past(run)) |-> (idx > $past(idx)));

  // R7: the scan takes a single cycle
  p_scan_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCAN) |=> (st != ST_SCAN));

endmodule

// File: rtl/vmask_exec.sv
module vmask_exec
  import vmask_pkg::*;
#(
  parameter int N = 8,
  parameter int W = 16,
  localparam int LW = $clog2(N + 1),
  localparam int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op,
  input  logic [LW-1:0]  vlen,
  input  logic           dense,
  input  logic [N*W-1:0] src_a,
  input  logic [N*W-1:0] src_b,
  output logic           busy,
  output logic           wr_en,
  output logic [IW-1:0]  wr_idx,
  output logic [W-1:0]   wr_data,
  output logic           done
);

  logic [LW-1:0] vlen_eff;
  logic          go;
  logic          alu;
  logic [2:0]    op_q;
  logic [N-1:0]  mask;
  logic          run;
  logic          pick;
  logic [IW-1:0] idx;
  logic [W-1:0]  a_el [N];
  logic [W-1:0]  b_el [N];

  function automatic logic [W-1:0] elem_calc(input logic [2:0] o,
                                             input logic [W-1:0] x,
                                             input logic [W-1:0] y);
    logic [W-1:0] r;
    if (o == OP_MUL) r = x * y;
    else             r = x + y;
    return r;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_el
    assign a_el[g] = src_a[g*W +: W];
    assign b_el[g] = src_b[g*W +: W];
  end

  assign vlen_eff = (vlen > LW'(N)) ? LW'(N) : vlen;
  assign go       = start & ~busy;
  assign alu      = is_alu_op(op);

  always_ff @(posedge clk) begin
    if (!rst_n)  op_q <= OP_ADD;
    else if (go) op_q <= op;
  end

  vmask_reg #(.N(N), .W(W)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (go & ~alu),
    .op       (op),
    .vlen_eff (vlen_eff),
    .src_a    (src_a),
    .src_b    (src_b),
    .mask     (mask)
  );

  vmask_seq #(.N(N)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .alu      (alu),
    .dense_in (dense),
    .vlen_eff (vlen_eff),
    .mask     (mask),
    .busy     (busy),
    .run      (run),
    .pick     (pick),
    .idx      (idx),
    .done     (done)
  );

  assign wr_en   = pick;
  assign wr_idx  = idx;
  assign wr_data = elem_calc(op_q, a_el[idx], b_el[idx]);

  // R6: every write lands on an element whose mask bit is set
  p_wr_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mask[wr_idx]);

  // R6: writes only happen while an element is being issued
  p_wr_in_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (run && busy));

endmodule

// File: tb/sim_vmask_exec.sv
`timescale 1ns/1ps
module sim_vmask_exec;
  localparam int N  = 8;
  localparam int W  = 16;
  localparam int LW = $clog2(N + 1);
  localparam int IW = $clog2(N);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [2:0]     op = '0;
  logic [LW-1:0]  vlen = '0;
  logic           dense = 1'b0;
  logic [N*W-1:0] va = '0;
  logic [N*W-1:0] vb = '0;
  logic           busy, wr_en, done;
  logic [IW-1:0]  wr_idx;
  logic [W-1:0]   wr_data;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;
  bit  mdl [N];

  always #2 clk = ~clk;

  vmask_exec #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .vlen(vlen),
    .dense(dense), .src_a(va), .src_b(vb), .busy(busy), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_el(input int i, input int a, input int b);
    va[i*W +: W] = a[W-1:0];
    vb[i*W +: W] = b[W-1:0];
  endtask

  task automatic run_op(input logic [2:0] o, input int vl, input bit dn,
                        input int poke, input string tag);
    int gi[N]; int gd[N]; int gc[N];
    int gn = 0; int dc = -1; int vle; int k = 0;
    longint ea, eb, ed;
    @(negedge clk);
    op = o; vlen = vl[LW-1:0]; dense = dn; start = 1'b1;
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (c == 1) begin
        start = 1'b0;
        chk(busy === 1'b1, "R10", {tag, " busy after accept"}, busy, 1);
      end
      if (wr_en === 1'b1) begin
        if (gn < N) begin gi[gn] = wr_idx; gd[gn] = wr_data; gc[gn] = c; end
        gn++;
      end
      if (done === 1'b1) begin dc = c; break; end
      if (c == poke) begin start = 1'b1; op = 3'd2; end
      else if (c == poke + 1) begin start = 1'b0; op = o; end
    end
    vle = (vl > N) ? N : vl;
    if (o >= 3'd2) begin
      chk(gn == 0, "R1", {tag, " mask op writes"}, gn, 0);
      chk(dc == 1, "R1", {tag, " mask op done cycle"}, dc, 1);
      if (o <= 3'd5) begin
        for (int i = 0; i < N; i++) begin
          ea = va[i*W +: W]; eb = vb[i*W +: W];
          if (i >= vle)        mdl[i] = 1'b0;
          else if (o == 3'd2)  mdl[i] = ea >= eb;
          else if (o == 3'd3)  mdl[i] = ea == 0;
          else if (o == 3'd4)  mdl[i] = ea != 0;
          else                 mdl[i] = !mdl[i];
        end
      end
    end else begin
      for (int i = 0; i < vle; i++) begin
        if (mdl[i]) begin
          ea = va[i*W +: W]; eb = vb[i*W +: W];
          ed = (o == 3'd0) ? ((ea + eb) & 64'hFFFF) : ((ea * eb) & 64'hFFFF);
          if (k < gn && k < N) begin
            chk(gi[k] == i, dn ? "R7" : "R6", {tag, " write index"}, gi[k], i);
            chk(gd[k] == ed, "R5", {tag, " write data"}, gd[k], ed);
            chk(gc[k] == (dn ? k + 2 : i + 1), dn ? "R7" : "R6",
                {tag, " write cycle"}, gc[k], dn ? k + 2 : i + 1);
          end
          k++;
        end
      end
      chk(gn == k, "R8", {tag, " write count"}, gn, k);
      chk(dc == (dn ? k + 2 : vle + 1), "R9", {tag, " done cycle"}, dc,
          dn ? k + 2 : vle + 1);
    end
  endtask

  task automatic t_reset();
    chk(busy === 1'b0, "R10", "reset busy", busy, 0);
    chk(done === 1'b0, "R10", "reset done", done, 0);
    chk(wr_en === 1'b0, "R10", "reset wr_en", wr_en, 0);
    for (int i = 0; i < N; i++) begin mdl[i] = 1'b1; set_el(i, 100 * i + 7, 3 * i); end
    run_op(3'd0, N, 1'b0, 0, "R1 reset mask all ones, sweep add");
  endtask

  task automatic t_mul_dense();
    for (int i = 0; i < N; i++) set_el(i, 16'hF000 + i * 311, 16'h0101 * (i + 3));
    run_op(3'd1, N, 1'b1, 0, "R5 packed multiply wraps");
  endtask

  task automatic t_cmpge();
    for (int i = 0; i < N; i++) set_el(i, (i % 3 == 0) ? 500 : 40000 + i, (i % 3 == 1) ? 40000 + i : 60000);
    set_el(7, 16'hFFFF, 16'h8000);
    run_op(3'd2, N, 1'b0, 0, "R2 compare ge");
    run_op(3'd0, N, 1'b0, 0, "R2 observe compare ge mask");
  endtask

  task automatic t_inv();
    run_op(3'd5, 6, 1'b0, 0, "R4 complement below length 6");
    run_op(3'd0, N, 1'b1, 0, "R4 observe complement, packed");
  endtask

  task automatic t_tests();
    for (int i = 0; i < N; i++) set_el(i, (i == 1 || i == 4 || i == 6) ? 0 : i + 9, 20 + i);
    run_op(3'd3, N, 1'b0, 0, "R3 test zero");
    run_op(3'd1, N, 1'b0, 0, "R3 observe test zero, sweep");
    run_op(3'd4, 5, 1'b1, 0, "R3 test nonzero length 5");
    run_op(3'd0, N, 1'b1, 0, "R8 observe tail cleared, packed");
  endtask

  task automatic t_vlen();
    for (int i = 0; i < N; i++) set_el(i, 1000 + i, 2 * i + 1);
    run_op(3'd4, 15, 1'b0, 0, "R8 test nonzero clamped length");
    run_op(3'd0, 3, 1'b0, 0, "R8 sweep length 3");
    run_op(3'd0, 15, 1'b1, 0, "R8 packed length clamped");
    run_op(3'd6, N, 1'b0, 0, "R1 reserved op keeps mask");
    run_op(3'd0, N, 1'b0, 0, "R1 observe after reserved op");
  endtask

  task automatic t_empty();
    run_op(3'd3, N, 1'b0, 0, "R9 test zero on nonzero data");
    run_op(3'd0, N, 1'b1, 0, "R9 packed empty mask");
    run_op(3'd0, 0, 1'b0, 0, "R9 sweep length 0");
    run_op(3'd0, N, 1'b0, 0, "R6 sweep with empty mask");
  endtask

  task automatic t_busy();
    for (int i = 0; i < N; i++) set_el(i, 5 + i, (i < 4) ? 1 : 60000);
    run_op(3'd4, N, 1'b0, 0, "R10 set mask all ones");
    run_op(3'd0, N, 1'b0, 3, "R10 start while busy ignored");
    run_op(3'd1, N, 1'b1, 0, "R10 mask untouched by ignored start");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mul_dense();
    t_cmpge();
    t_inv();
    t_tests();
    t_vlen();
    t_empty();
    t_busy();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule